// File: doc/BRIEF.md
# Single-Cycle Datapath with Register-Indexed Load

This block is a reduced 32-bit single-cycle processor core. Each clock cycle it fetches one instruction from an external instruction memory, decodes it, reads the register file, computes a result and writes it back. The supported instructions are R-format add and sub, word load, word store and branch-on-equal. It also supports an indexed load that returns the word at `rt + (4 + rs)` and writes it into register `rd`.

The indexed load still finishes in one cycle. No functional unit may serve twice within an instruction, so the core adds a dedicated "+4" adder beside the main ALU. A new select line chooses between the `rs` value and the adder result as the ALU's first operand. The main ALU then adds `rt` as its second operand.

The instruction memory and the data memory sit outside the core. Both are read combinationally. The data memory is written on the rising clock edge when the write enable is high.

Top module: `sc_core`

## Requirements
- R1: The reset input is asynchronous and active low. While it is low, `imem_addr` is 0 and both `dmem_we` and `dmem_re` are 0. After it rises, `imem_addr` stays 0 for two more rising edges, because the internal reset passes through a two-stage synchronizer.
- R2: Except on a taken branch, `imem_addr` (a word address) increases by one on each rising edge once the synchronized reset has been released.
- R3: When the opcode is 6'h00, funct 6'h20 writes `rs + rt` to `rd` and funct 6'h22 writes `rs - rt` to `rd`. The fields are rs = [25:21], rt = [20:16] and rd = [15:11].
- R4: Opcode 6'h23 writes the data-memory word at `rs + sext(imm16)` to `rt`. The offset may be negative.
- R5: Opcode 6'h2B drives `rs + sext(imm16)` on `dmem_addr` and the value of `rt` on `dmem_wdata`, with `dmem_we` high for that one cycle only. No register is written.
- R6: When the opcode is 6'h00, funct 6'h38 raises `dmem_re`, drives `dmem_addr = rt + (4 + rs)` in that same cycle, and writes the returned word to `rd`. This holds for negative values of `rs`.
- R7: The indexed load gives the correct result when `rs` and `rt` name the same register, so the address is `2*rs + 4`.
- R8: Opcode 6'h04 compares `rs` with `rt`. If they are equal, the next `imem_addr` is `imem_addr + 1 + sext(imm16)`. Otherwise it is `imem_addr + 1`.
- R9: A write to register 0 is dropped, and register 0 always reads as zero.
- R10: Any other opcode, and any other funct value under opcode 6'h00, writes no register and no memory.
- R11: `dmem_we` and `dmem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | IAW (30) | Word address of the instruction being fetched |
| imem_rdata | input | XLEN (32) | Instruction word at `imem_addr` |
| dmem_addr | output | XLEN (32) | Byte address for the data access; bits [31:2] select the word |
| dmem_wdata | output | XLEN (32) | Data to store |
| dmem_we | output | 1 | Data-memory write enable, sampled at the rising edge |
| dmem_re | output | 1 | Data-memory read request |
| dmem_rdata | input | XLEN (32) | Word read combinationally at `dmem_addr` |

## Verification
The assertions assume that both memories answer combinationally within the cycle. They also assume that every data address is word aligned, because the core never checks the two low address bits. The test program respects both assumptions: it sets every base register from preloaded aligned values and uses only offsets that are multiples of four, including negative ones. Instruction words outside the program read as zero, which decodes as an unsupported funct. The program ends in a self-branch, so execution never runs past its end.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_IDXLD = 6'h38;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aop_e;

  typedef struct packed {
    logic reg_dst;     // 1: write rd, 0: write rt
    logic reg_write;
    logic alu_src;     // 1: sign-extended immediate, 0: rt value
    aop_e alu_op;
    logic mem_write;
    logic mem_read;
    logic mem_to_reg;
    logic branch;
    logic a_plus4;     // 1: ALU operand A comes from the dedicated +4 adder
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = AOP_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctl.reg_dst   = 1'b1;
          ctl.reg_write = 1'b1;
          ctl.alu_op    = AOP_FUNCT;
        end else if (funct == FN_IDXLD) begin
          ctl.reg_dst    = 1'b1;
          ctl.reg_write  = 1'b1;
          ctl.mem_read   = 1'b1;
          ctl.mem_to_reg = 1'b1;
          ctl.a_plus4    = 1'b1;
          ctl.alu_op     = AOP_ADD;
        end
      end
      OP_LOAD: begin
        ctl.reg_write  = 1'b1;
        ctl.alu_src    = 1'b1;
        ctl.mem_read   = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctl.alu_src   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      default: ctl = '0;
    endcase
  end

  // R10: anything outside the decoded set leaves state untouched
  always_comb begin
    if (!(opcode inside {OP_LOAD, OP_STORE, OP_BEQ}) &&
        !(opcode == OP_RTYPE && funct inside {FN_ADD, FN_SUB, FN_IDXLD})) begin
      assert_unknown_nop_R10: assert (!ctl.reg_write && !ctl.mem_write && !ctl.mem_read);
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  aop_e            op,
  input  logic [5:0]      funct,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  logic do_sub;

  always_comb begin
    unique case (op)
      AOP_SUB:   do_sub = 1'b1;
      AOP_FUNCT: do_sub = (funct == FN_SUB);
      default:   do_sub = 1'b0;
    endcase
  end

  assign y    = do_sub ? (a - b) : (a + b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign view[g] = '0;
    end else begin : g_store
      logic            en;
      logic [XLEN-1:0] q;
      assign en = we && (wa == AW'(g));
      always_ff @(posedge clk) begin
        if (en) q <= wd;
      end
      assign view[g] = q;
    end
  end

  assign rd1 = view[ra1];
  assign rd2 = view[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IAW  = 30,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [IAW-1:0]  imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int RAW = $clog2(NREG);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  // instruction fields
  logic [5:0]      opcode, funct;
  logic [RAW-1:0]  f_rs, f_rt, f_rd;
  logic [XLEN-1:0] imm_sext;
  logic            unused_shamt;
  assign opcode       = imem_rdata[31:26];
  assign f_rs         = imem_rdata[21+RAW-1:21];
  assign f_rt         = imem_rdata[16+RAW-1:16];
  assign f_rd         = imem_rdata[11+RAW-1:11];
  assign funct        = imem_rdata[5:0];
  assign imm_sext     = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};
  assign unused_shamt = ^imem_rdata[10:6];

  ctrl_t ctl;
  sc_ctrl u_ctrl (.opcode(opcode), .funct(funct), .ctl(ctl));

  // register file
  logic [XLEN-1:0] rs_val, rt_val, wb_data;
  logic [RAW-1:0]  wb_addr;
  logic            rf_we;
  assign wb_addr = ctl.reg_dst ? f_rd : f_rt;
  assign rf_we   = ctl.reg_write && run;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .ra1(f_rs), .ra2(f_rt), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(wb_addr), .wd(wb_data)
  );

  // dedicated +4 adder for the indexed load, ahead of the main ALU
  logic [XLEN-1:0] base_plus4, alu_a, alu_b, alu_y;
  logic            alu_zero;
  assign base_plus4 = rs_val + XLEN'(4);
  assign alu_a      = ctl.a_plus4 ? base_plus4 : rs_val;
  assign alu_b      = ctl.alu_src ? imm_sext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a(alu_a), .b(alu_b), .op(ctl.alu_op), .funct(funct),
    .y(alu_y), .zero(alu_zero)
  );

  assign wb_data    = ctl.mem_to_reg ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_write && run;
  assign dmem_re    = ctl.mem_read && run;

  // program counter, in words
  logic [IAW-1:0] pc_q, pc_d, pc_inc, pc_tgt;
  logic           pc_en, take_br;
  assign pc_inc  = pc_q + IAW'(1);
  assign pc_tgt  = pc_inc + imm_sext[IAW-1:0];
  assign take_br = ctl.branch && alu_zero;
  assign pc_en   = run;

  always_comb begin
    pc_d = take_br ? pc_tgt : pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  // checks
  assert_mem_excl_R11: assert property (@(posedge clk) disable iff (!run)
    !(dmem_we && dmem_re));

  assert_idx_addr_R6: assert property (@(posedge clk) disable iff (!run)
    (dmem_re && opcode == OP_RTYPE) |-> (dmem_addr == rt_val + rs_val + XLEN'(4)));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!run)
    !ctl.branch |=> (imem_addr == $past(imem_addr) + IAW'(1)));

  assert_beq_taken_R8: assert property (@(posedge clk) disable iff (!run)
    (ctl.branch && rs_val == rt_val) |=>
      (imem_addr == $past(imem_addr) + IAW'(1) + $past(imm_sext[IAW-1:0])));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !run |-> (!dmem_we && !dmem_re));
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int XLEN = 32;
  localparam int IAW  = 30;
  localparam int PLEN = 26;
  localparam int NEXP = 11;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  localparam logic [31:0] PROG [PLEN] = '{
    enc_i(6'h23, 0, 1, 16'd0),      // 0  r1 = 4
    enc_i(6'h23, 0, 2, 16'd4),      // 1  r2 = 8
    enc_i(6'h23, 0, 3, 16'd8),      // 2  r3 = -8
    enc_r(1, 2, 4, 6'h38),          // 3  r4 = M[16]
    enc_r(2, 2, 5, 6'h38),          // 4  r5 = M[20] (rs == rt)
    enc_r(3, 2, 6, 6'h38),          // 5  r6 = M[4]  (negative rs)
    enc_r(4, 5, 7, 6'h20),          // 6  r7 = r4 + r5
    enc_r(4, 5, 8, 6'h22),          // 7  r8 = r4 - r5
    enc_r(1, 2, 0, 6'h20),          // 8  write to r0
    enc_r(1, 2, 0, 6'h38),          // 9  indexed load into r0
    enc_i(6'h08, 0, 1, 16'h0055),   // 10 unknown opcode
    enc_r(1, 1, 2, 6'h21),          // 11 unknown funct
    enc_i(6'h04, 1, 2, 16'd1),      // 12 beq not taken
    enc_i(6'h2B, 0, 1, 16'd40),     // 13
    enc_i(6'h04, 1, 1, 16'd1),      // 14 beq taken -> 16
    enc_i(6'h2B, 0, 2, 16'd44),     // 15 skipped
    enc_i(6'h2B, 0, 7, 16'd48),     // 16
    enc_i(6'h2B, 0, 8, 16'd52),     // 17
    enc_i(6'h2B, 0, 6, 16'd56),     // 18
    enc_i(6'h2B, 0, 0, 16'd60),     // 19
    enc_i(6'h2B, 0, 1, 16'd64),     // 20
    enc_i(6'h2B, 0, 2, 16'd68),     // 21
    enc_i(6'h2B, 0, 4, 16'd72),     // 22
    enc_i(6'h2B, 0, 5, 16'd76),     // 23
    enc_i(6'h2B, 2, 4, 16'hFFF8),   // 24 M[0] = r4
    enc_i(6'h04, 0, 0, 16'hFFFF)    // 25 self loop
  };

  // expected final data words: word index, value, requirement code
  localparam int          EXP_IDX [NEXP] = '{12, 13, 19, 14, 16, 17, 10, 11, 15, 0, 18};
  localparam logic [31:0] EXP_VAL [NEXP] = '{32'h2009, 32'hFFFF_FFFF, 32'h1005, 32'd8, 32'd4,
                                             32'd8, 32'd4, 32'h100B, 32'd0, 32'h1004, 32'h1004};
  localparam int          EXP_REQ [NEXP] = '{3, 3, 7, 6, 10, 10, 8, 8, 9, 5, 4};

  function automatic string tag(input int k);
    case (k)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R10";
    endcase
  endfunction

  logic            clk = 1'b0;
  logic            rst_n;
  logic [IAW-1:0]  imem_addr;
  logic [XLEN-1:0] imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic            dmem_we, dmem_re;
  logic [31:0]     dmem [64];
  int              n_checks = 0;
  int              n_errors = 0;
  bit              done = 1'b0;

  always #5 clk = ~clk;

  assign imem_rdata = (imem_addr < IAW'(PLEN)) ? PROG[imem_addr[4:0]] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  sc_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int prev;
    bit loop_seen;
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h1000 + i;
    dmem[0] = 32'd4;
    dmem[1] = 32'd8;
    dmem[2] = 32'hFFFF_FFF8;
    dmem[3] = 32'd0;

    // R1: quiet while held in reset
    repeat (3) @(negedge clk);
    check(imem_addr == 0, "R1", 32'(imem_addr), 0);
    check(!dmem_we && !dmem_re, "R1", {30'd0, dmem_we, dmem_re}, 0);

    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(imem_addr == 0, "R1", 32'(imem_addr), 0);   // synchronizer delay
    @(negedge clk);
    check(imem_addr == 1, "R2", 32'(imem_addr), 1);

    prev = 1;
    loop_seen = 1'b0;
    for (int c = 0; c < 60; c++) begin
      check(!(dmem_we && dmem_re), "R11", {30'd0, dmem_we, dmem_re}, 0);
      case (imem_addr)
        3:  check(dmem_re && dmem_addr == 16, "R6", dmem_addr, 16);
        4:  check(dmem_re && dmem_addr == 20, "R7", dmem_addr, 20);
        5:  check(dmem_re && dmem_addr == 4, "R6", dmem_addr, 4);
        10, 11: check(!dmem_we && !dmem_re, "R10", {30'd0, dmem_we, dmem_re}, 0);
        13: check(dmem_we && dmem_addr == 40 && dmem_wdata == 4, "R5", dmem_addr, 40);
        default: ;
      endcase
      @(negedge clk);
      if (prev == 1)  check(imem_addr == 2, "R2", 32'(imem_addr), 2);
      if (prev == 12) check(imem_addr == 13, "R8", 32'(imem_addr), 13);
      if (prev == 14) check(imem_addr == 16, "R8", 32'(imem_addr), 16);
      if (prev == 25 && !loop_seen) begin
        check(imem_addr == 25, "R8", 32'(imem_addr), 25);
        loop_seen = 1'b1;
      end
      prev = int'(imem_addr);
    end

    // final memory image against expected table
    for (int k = 0; k < NEXP; k++) begin
      check(dmem[EXP_IDX[k]] == EXP_VAL[k], tag(EXP_REQ[k]), dmem[EXP_IDX[k]], EXP_VAL[k]);
    end
    check(dmem[1] == 32'd8, "R4", dmem[1], 32'd8);

    // R1: asynchronous assertion mid-cycle
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check(imem_addr == 0, "R1", 32'(imem_addr), 0);
    check(!dmem_we && !dmem_re, "R1", {30'd0, dmem_we, dmem_re}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule